// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order processor core split into five stages: fetch, decode with register read, execute, memory access and write-back. It runs a seven-instruction integer subset: register add and subtract, OR with an immediate, word load, word store, branch on equal and absolute jump. Registers between the stages carry each instruction's operands, its decoded control bits and its destination register number, so up to five instructions are in flight at once.

The core has a fetch port (address out, instruction word in, read in the same cycle) and a data port (address, write data, write strobe out; read data in, read in the same cycle). A retire strobe reports, in the write-back cycle, every register write together with the register number and the value. The core does no forwarding and never stalls. The instruction stream must keep a producer's decode and its consumer's decode at least three cycles apart, which means two independent words or no-ops between them. Branches and jumps take effect from the execute stage.

Top module: `pipe5_core`

## Requirements
- R1: While reset is held and in the first cycle after it, every pipeline register is a bubble: ret_valid and dmem_we are low and imem_addr equals RESET_PC.
- R2: Without a redirect, imem_addr grows by 4 every cycle.
- R3: A word fetched in cycle n retires in cycle n+4. Consecutive register-writing words retire in consecutive cycles.
- R4: Opcode 0 with funct 0x20 writes rs+rt to rd, and with funct 0x22 writes rs-rt to rd. The opcode is bits 31:26; rs, rt and rd are bits 25:21, 20:16 and 15:11; funct is bits 5:0.
- R5: Opcode 0x0D writes rs OR the zero-extended 16-bit immediate (bits 15:0) to rt.
- R6: Opcode 0x23 reads the data port at rs + sign-extended immediate during its memory cycle and writes the word to rt.
- R7: Opcode 0x2B drives dmem_we for exactly one cycle, three cycles after its fetch, with address rs + sign-extended immediate and data rt. It never raises ret_valid.
- R8: A register written back in a cycle is read with its new value by the word in decode in that same cycle.
- R9: Opcode 0x04, when rs equals rt, sends fetch to (address of branch + 4) + (sign-extended immediate << 2) in the cycle after its execute stage and discards the two words fetched behind it. When not equal, fetch continues in order.
- R10: Opcode 0x02 sends fetch to {upper 4 bits of its address + 4, bits 25:0, 2'b00} and discards the two words fetched behind it.
- R11: ret_valid is high only for words that write a nonzero register. Writes to register 0 are dropped, and register 0 reads as zero.
- R12: The write-back register number is the one decoded with the retiring word, whatever word is then in decode.
- R13: The all-zero word and every other unlisted opcode or funct act as bubbles: no register write and no data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | XLEN | Fetch address (program counter) |
| imem_data | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | XLEN | Data port byte address |
| dmem_wdata | output | XLEN | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | XLEN | Load data at dmem_addr, same cycle |
| ret_valid | output | 1 | A register write retires this cycle |
| ret_reg | output | log2(NREGS) | Retiring destination register |
| ret_data | output | XLEN | Retiring value |

## Verification
The in-RTL assertions watch these properties on every cycle: fetch advancing by 4 when nothing redirects it, the two bubbles that follow a redirect in the execute register, the silent write-back slot that follows every store, and the ban on retiring register 0. The bench programs alone can show the values computed: sums, differences, zero extension, load and store data, and sign-extended offsets. They also show exact retire cycles, the same-cycle register write-through, the words a branch or jump discards, and the skipped target gap. Unlisted encodings are shown to be harmless by the absence of retire events and stores at the ports.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_JMP   = 6'h02;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_ORI   = 6'h0D;
   localparam logic [5:0] OP_LOAD  = 6'h23;
   localparam logic [5:0] OP_STORE = 6'h2B;
   localparam logic [5:0] FN_ADD   = 6'h20;
   localparam logic [5:0] FN_SUB   = 6'h22;

   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_OR  = 2'd2
   } alu_op_e;

   typedef struct packed {
      logic    reg_wr;
      logic    mem_wr;
      logic    mem_rd;
      logic    use_imm;
      logic    sext;
      logic    is_beq;
      logic    is_jmp;
      logic    dst_rd;
      alu_op_e alu;
   } ctrl_t;

endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
   import pipe5_pkg::*;
(
   input  logic [31:0] instr,
   output ctrl_t       ctrl
);

   logic [5:0] opc;
   logic [5:0] fn;
   logic       unused_fields;

   assign opc = instr[31:26];
   assign fn  = instr[5:0];
   assign unused_fields = ^instr[25:6];

   always_comb begin
      ctrl     = '0;
      ctrl.alu = ALU_ADD;
      unique case (opc)
         OP_RTYPE: begin
            if (fn == FN_ADD) begin
               ctrl.reg_wr = 1'b1;
               ctrl.dst_rd = 1'b1;
            end else if (fn == FN_SUB) begin
               ctrl.reg_wr = 1'b1;
               ctrl.dst_rd = 1'b1;
               ctrl.alu    = ALU_SUB;
            end
         end
         OP_ORI: begin
            ctrl.reg_wr  = 1'b1;
            ctrl.use_imm = 1'b1;
            ctrl.alu     = ALU_OR;
         end
         OP_LOAD: begin
            ctrl.reg_wr  = 1'b1;
            ctrl.mem_rd  = 1'b1;
            ctrl.use_imm = 1'b1;
            ctrl.sext    = 1'b1;
         end
         OP_STORE: begin
            ctrl.mem_wr  = 1'b1;
            ctrl.use_imm = 1'b1;
            ctrl.sext    = 1'b1;
         end
         OP_BEQ: begin
            ctrl.is_beq = 1'b1;
            ctrl.sext   = 1'b1;
            ctrl.alu    = ALU_SUB;
         end
         OP_JMP: begin
            ctrl.is_jmp = 1'b1;
         end
         default: ctrl = '0;
      endcase
   end

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
   import pipe5_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   input  alu_op_e      op,
   output logic [W-1:0] res,
   output logic         zero
);

   always_comb begin
      unique case (op)
         ALU_SUB: res = opa - opb;
         ALU_OR:  res = opa | opb;
         default: res = opa + opb;
      endcase
   end

   assign zero = (res == '0);

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
   parameter int unsigned W           = 32,
   parameter int unsigned DEPTH       = 32,
   parameter bit          WRITE_FIRST = 1'b1,
   localparam int unsigned AW         = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   output logic [W-1:0]  rd1,
   output logic [W-1:0]  rd2
);

   logic [W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we && wa != '0) cells[wa] <= wd;
   end

   generate
      if (WRITE_FIRST) begin : g_wr_first
         always_comb begin
            rd1 = (ra1 == '0) ? '0 : (we && wa == ra1) ? wd : cells[ra1];
            rd2 = (ra2 == '0) ? '0 : (we && wa == ra2) ? wd : cells[ra2];
         end
      end else begin : g_rd_first
         always_comb begin
            rd1 = (ra1 == '0) ? '0 : cells[ra1];
            rd2 = (ra2 == '0) ? '0 : cells[ra2];
         end
      end
   endgenerate

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
   import pipe5_pkg::*;
#(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned NREGS       = 32,
   parameter logic [31:0] RESET_PC    = 32'h0000_0000,
   parameter bit          WRITE_FIRST = 1'b1,
   localparam int unsigned RAW        = $clog2(NREGS)
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] imem_addr,
   input  logic [31:0]     imem_data,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   output logic            dmem_we,
   input  logic [XLEN-1:0] dmem_rdata,
   output logic            ret_valid,
   output logic [RAW-1:0]  ret_reg,
   output logic [XLEN-1:0] ret_data
);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("pipe5_core: XLEN must be 32 for this encoding");
      end
      if (NREGS > 32 || NREGS < 2 || (1 << RAW) != NREGS) begin : g_bad_nregs
         $error("pipe5_core: NREGS must be a power of two from 2 to 32");
      end
   endgenerate

   typedef struct packed {
      logic            valid;
      logic [31:0]     instr;
      logic [XLEN-1:0] pc4;
   } fd_t;

   typedef struct packed {
      logic            valid;
      ctrl_t           ctrl;
      logic [XLEN-1:0] a;
      logic [XLEN-1:0] b;
      logic [XLEN-1:0] imm;
      logic [XLEN-1:0] pc4;
      logic [RAW-1:0]  dest;
      logic [25:0]     jidx;
   } dx_t;

   typedef struct packed {
      logic            reg_wr;
      logic            mem_wr;
      logic            mem_rd;
      logic [RAW-1:0]  dest;
      logic [XLEN-1:0] y;
      logic [XLEN-1:0] sdata;
   } xm_t;

   typedef struct packed {
      logic            reg_wr;
      logic [RAW-1:0]  dest;
      logic [XLEN-1:0] value;
   } mw_t;

   logic [XLEN-1:0] pc;
   fd_t fd_q;
   dx_t dx_q, dx_d;
   xm_t xm_q, xm_d;
   mw_t mw_q, mw_d;

   ctrl_t           dec_ctrl;
   logic [RAW-1:0]  id_rs, id_rt, id_rd, id_dest;
   logic [XLEN-1:0] rf_a, rf_b;
   logic [XLEN-1:0] alu_b, alu_y;
   logic            alu_zero;
   logic            ex_redirect;
   logic [XLEN-1:0] ex_target;

   // ---------------- fetch ----------------
   assign imem_addr = pc;

   // ---------------- decode ----------------
   pipe5_decode u_dec (
      .instr (fd_q.instr),
      .ctrl  (dec_ctrl)
   );

   assign id_rs   = fd_q.instr[21 +: RAW];
   assign id_rt   = fd_q.instr[16 +: RAW];
   assign id_rd   = fd_q.instr[11 +: RAW];
   assign id_dest = dec_ctrl.dst_rd ? id_rd : id_rt;

   pipe5_regfile #(
      .W           (XLEN),
      .DEPTH       (NREGS),
      .WRITE_FIRST (WRITE_FIRST)
   ) u_rf (
      .clk (clk),
      .we  (mw_q.reg_wr),
      .wa  (mw_q.dest),
      .wd  (mw_q.value),
      .ra1 (id_rs),
      .ra2 (id_rt),
      .rd1 (rf_a),
      .rd2 (rf_b)
   );

   always_comb begin
      dx_d        = '0;
      dx_d.valid  = fd_q.valid;
      dx_d.ctrl   = fd_q.valid ? dec_ctrl : ctrl_t'('0);
      dx_d.ctrl.reg_wr = fd_q.valid && dec_ctrl.reg_wr && (id_dest != '0);
      dx_d.a      = rf_a;
      dx_d.b      = rf_b;
      dx_d.imm    = {{(XLEN-16){dec_ctrl.sext & fd_q.instr[15]}}, fd_q.instr[15:0]};
      dx_d.pc4    = fd_q.pc4;
      dx_d.dest   = id_dest;
      dx_d.jidx   = fd_q.instr[25:0];
   end

   // ---------------- execute ----------------
   assign alu_b = dx_q.ctrl.use_imm ? dx_q.imm : dx_q.b;

   pipe5_alu #(.W(XLEN)) u_alu (
      .opa  (dx_q.a),
      .opb  (alu_b),
      .op   (dx_q.ctrl.alu),
      .res  (alu_y),
      .zero (alu_zero)
   );

   assign ex_redirect = dx_q.valid &&
                        ((dx_q.ctrl.is_beq && alu_zero) || dx_q.ctrl.is_jmp);
   assign ex_target   = dx_q.ctrl.is_jmp
                        ? {dx_q.pc4[XLEN-1 -: 4], dx_q.jidx, 2'b00}
                        : dx_q.pc4 + (dx_q.imm << 2);

   always_comb begin
      xm_d.reg_wr = dx_q.ctrl.reg_wr;
      xm_d.mem_wr = dx_q.ctrl.mem_wr;
      xm_d.mem_rd = dx_q.ctrl.mem_rd;
      xm_d.dest   = dx_q.dest;
      xm_d.y      = alu_y;
      xm_d.sdata  = dx_q.b;
   end

   // ---------------- memory ----------------
   assign dmem_addr  = xm_q.y;
   assign dmem_wdata = xm_q.sdata;
   assign dmem_we    = xm_q.mem_wr;

   always_comb begin
      mw_d.reg_wr = xm_q.reg_wr;
      mw_d.dest   = xm_q.dest;
      mw_d.value  = xm_q.mem_rd ? dmem_rdata : xm_q.y;
   end

   // ---------------- write-back ----------------
   assign ret_valid = mw_q.reg_wr;
   assign ret_reg   = mw_q.dest;
   assign ret_data  = mw_q.value;

   // ---------------- stage registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc   <= RESET_PC[XLEN-1:0];
         fd_q <= '0;
         dx_q <= '0;
         xm_q <= '0;
         mw_q <= '0;
      end else begin
         pc         <= ex_redirect ? ex_target : pc + XLEN'(4);
         fd_q.valid <= !ex_redirect;
         fd_q.instr <= imem_data;
         fd_q.pc4   <= pc + XLEN'(4);
         dx_q       <= ex_redirect ? dx_t'('0) : dx_d;
         xm_q       <= xm_d;
         mw_q       <= mw_d;
      end
   end

   // ---------------- assertions ----------------
   assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_redirect |=> imem_addr == $past(imem_addr) + XLEN'(4));

   assert_flush_two_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ex_redirect |=> !dx_q.valid ##1 !dx_q.valid);

   assert_store_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_we |=> !ret_valid);

   assert_no_r0_retire_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |-> ret_reg != '0);

endmodule

// File: tb/pipe5_core_test.sv
`timescale 1ns/1ps
module pipe5_core_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] imem_addr, imem_data;
   logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we;
   logic        ret_valid;
   logic [4:0]  ret_reg;
   logic [31:0] ret_data;

   logic [31:0] prog [64];
   logic [31:0] dram [64];

   int nchk = 0;
   int nfail = 0;
   int cyc;

   int          rcnt;
   logic [4:0]  rlog_reg [64];
   logic [31:0] rlog_dat [64];
   int          rlog_cyc [64];
   int          scnt;
   logic [31:0] slog_addr, slog_dat;
   int          slog_cyc;

   always #2 clk = ~clk;

   pipe5_core uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .imem_addr  (imem_addr),
      .imem_data  (imem_data),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_we    (dmem_we),
      .dmem_rdata (dmem_rdata),
      .ret_valid  (ret_valid),
      .ret_reg    (ret_reg),
      .ret_data   (ret_data)
   );

   assign imem_data  = prog[imem_addr[7:2]];
   assign dmem_rdata = dram[dmem_addr[7:2]];

   always @(posedge clk) begin
      if (dmem_we) dram[dmem_addr[7:2]] <= dmem_wdata;
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         rcnt = 0;
         scnt = 0;
      end else begin
         if (ret_valid && rcnt < 64) begin
            rlog_reg[rcnt] = ret_reg;
            rlog_dat[rcnt] = ret_data;
            rlog_cyc[rcnt] = cyc;
            rcnt = rcnt + 1;
         end
         if (dmem_we) begin
            slog_addr = dmem_addr;
            slog_dat  = dmem_wdata;
            slog_cyc  = cyc;
            scnt = scnt + 1;
         end
      end
   end

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction
   function automatic logic [31:0] enc_j(logic [25:0] idx);
      return {6'h02, idx};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 64; i++) begin
         prog[i] = 32'h0;
         dram[i] <= 32'h0;
      end
   endtask

   task automatic restart();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_ret(int i, int r, logic [31:0] d, int c, string req);
      chk(req, 32'(rlog_reg[i]), 32'(r));
      chk(req, rlog_dat[i], d);
      chk(req, 32'(rlog_cyc[i]), 32'(c));
   endtask

   // R1 reset state, R2 fetch stepping
   task automatic t_reset();
      clear_mem();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R1 ret_valid", 32'(ret_valid), 32'd0);
      chk("R1 dmem_we", 32'(dmem_we), 32'd0);
      chk("R1 imem_addr", imem_addr, 32'h0);
      #1 rst_n = 1'b1;
      #0;
      chk("R1 imem_addr after release", imem_addr, 32'h0);
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         chk("R2 fetch step", imem_addr, 32'(4 * k));
         chk("R13 no-op no retire", 32'(ret_valid), 32'd0);
      end
   endtask

   // R3 R4 R5 R8 R12 R13
   task automatic t_arith();
      clear_mem();
      prog[0] = enc_i(6'h0D, 0, 1, 16'h0005);
      prog[1] = enc_i(6'h0D, 0, 2, 16'h0003);
      prog[2] = enc_i(6'h0D, 0, 5, 16'h8001);
      prog[3] = 32'h0;
      prog[4] = enc_r(1, 2, 3, 6'h20);
      prog[5] = enc_r(1, 2, 4, 6'h22);
      prog[6] = enc_r(2, 1, 6, 6'h22);
      prog[7] = 32'hFC00_0000;
      prog[8] = enc_r(1, 2, 7, 6'h21);
      restart();
      run(20);
      chk("R13 retire count", 32'(rcnt), 32'd6);
      expect_ret(0, 1, 32'h5, 4, "R3 first retire");
      expect_ret(1, 2, 32'h3, 5, "R3 back-to-back");
      expect_ret(2, 5, 32'h0000_8001, 6, "R5 zero extend");
      expect_ret(3, 3, 32'h8, 8, "R8 add same-cycle write");
      expect_ret(4, 4, 32'h2, 9, "R4 sub");
      expect_ret(5, 6, 32'hFFFF_FFFE, 10, "R12 dest rd");
      chk("R13 no store", 32'(scnt), 32'd0);
   endtask

   // R6 R7 R11
   task automatic t_mem();
      clear_mem();
      dram[3] <= 32'hCAFE_0001;
      prog[0]  = enc_i(6'h0D, 0, 1, 16'h0010);
      prog[1]  = enc_i(6'h0D, 0, 2, 16'h1234);
      prog[4]  = enc_i(6'h2B, 1, 2, 16'h0004);
      prog[5]  = enc_i(6'h23, 1, 3, 16'h0004);
      prog[6]  = enc_i(6'h23, 1, 4, 16'hFFFC);
      prog[7]  = enc_i(6'h0D, 0, 0, 16'h0055);
      prog[10] = enc_r(0, 0, 7, 6'h20);
      restart();
      run(20);
      chk("R7 store count", 32'(scnt), 32'd1);
      chk("R7 store addr", slog_addr, 32'h14);
      chk("R7 store data", slog_dat, 32'h1234);
      chk("R7 store cycle", 32'(slog_cyc), 32'd7);
      chk("R7 memory", dram[5], 32'h1234);
      chk("R11 retire count", 32'(rcnt), 32'd5);
      expect_ret(0, 1, 32'h10, 4, "R5 base");
      expect_ret(1, 2, 32'h1234, 5, "R5 data");
      expect_ret(2, 3, 32'h1234, 9, "R6 load after store");
      expect_ret(3, 4, 32'hCAFE_0001, 10, "R6 negative offset");
      expect_ret(4, 7, 32'h0, 14, "R11 r0 stays zero");
   endtask

   // R9
   task automatic t_branch();
      clear_mem();
      prog[0]  = enc_i(6'h0D, 0, 1, 16'h0007);
      prog[1]  = enc_i(6'h0D, 0, 2, 16'h0007);
      prog[4]  = enc_i(6'h04, 1, 2, 16'h0003);
      prog[5]  = enc_i(6'h0D, 0, 3, 16'h0001);
      prog[6]  = enc_i(6'h0D, 0, 4, 16'h0002);
      prog[7]  = enc_i(6'h0D, 0, 5, 16'h0003);
      prog[8]  = enc_i(6'h0D, 0, 6, 16'h0009);
      prog[9]  = enc_i(6'h04, 1, 0, 16'h0005);
      prog[10] = enc_i(6'h0D, 0, 8, 16'h000A);
      restart();
      run(7);
      chk("R9 redirect address", imem_addr, 32'd32);
      run(13);
      chk("R9 retire count", 32'(rcnt), 32'd4);
      expect_ret(0, 1, 32'h7, 4, "R9 setup");
      expect_ret(1, 2, 32'h7, 5, "R9 setup");
      expect_ret(2, 6, 32'h9, 11, "R9 taken target");
      expect_ret(3, 8, 32'hA, 13, "R9 not taken falls through");
   endtask

   // R10
   task automatic t_jump();
      clear_mem();
      prog[0]  = enc_j(26'd12);
      prog[1]  = enc_i(6'h0D, 0, 1, 16'h0001);
      prog[2]  = enc_i(6'h0D, 0, 2, 16'h0002);
      prog[3]  = enc_i(6'h0D, 0, 3, 16'h0003);
      prog[12] = enc_i(6'h0D, 0, 9, 16'h0077);
      restart();
      run(3);
      chk("R10 jump address", imem_addr, 32'd48);
      run(12);
      chk("R10 retire count", 32'(rcnt), 32'd1);
      expect_ret(0, 9, 32'h77, 7, "R10 jump target");
   endtask

   initial begin
      t_reset();
      t_arith();
      t_mem();
      t_branch();
      t_jump();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule